// File: doc/BRIEF.md
# Two-Wire Slave Address Front End

This block sits at the bus edge of a combined memory and control device on a two-wire serial bus. It samples the clock and data lines on a fast system clock, finds START and STOP conditions, and shifts in the first byte after each START, most significant bit first. From that byte it decides whether this device is being addressed. The byte carries a fixed device-type code, a physical address bit that must match a strap pin, a two-bit selector naming an internal target, and a read/write bit.

When the byte is accepted the block pulls SDA low for the ninth clock, which is the acknowledge. It then holds a transaction-active flag, together with the selected target and the direction, so that the per-target data logic downstream can take over. Writes to the memory array and to the potentiometer wiper registers are acknowledged only while the write-enable latch input is set. Writes to the control/status register are always acknowledged. A rejected byte leaves SDA released, and the block ignores the bus until the next START.

The controller has six states:
- `ST_IDLE`: waiting for a START.
- `ST_SHIFT`: receiving the address bits.
- `ST_ACK_WAIT`: the byte is accepted and the block waits for SCL to go low before it drives.
- `ST_ACK_DRIVE`: SDA is held low through the ninth clock.
- `ST_ACTIVE`: the transaction is handed to the downstream logic.
- `ST_IGNORE`: the address was rejected.

Transitions:
- START in any state goes to `ST_SHIFT`.
- STOP in any state goes to `ST_IDLE`.
- `ST_SHIFT` goes to `ST_ACK_WAIT` or to `ST_IGNORE` on the eighth SCL rise.
- `ST_ACK_WAIT` goes to `ST_ACK_DRIVE` on the next SCL fall.
- `ST_ACK_DRIVE` goes to `ST_ACTIVE` on the ninth SCL fall.

Top module: `twsl_addr_front`

## Requirements
- R1: After a START, eight address bits are taken on SCL rising edges, MSB first. For an accepted byte, `sda_oe` rises after the SCL fall that follows the eighth bit. It falls again after the SCL fall that ends the ninth clock.
- R2: The byte is rejected (no acknowledge, `txn_active` stays 0) unless its bits 7:4 equal 1010.
- R3: Bit 3 must equal `addr_strap`, otherwise the byte is rejected.
- R4: Bits 2:1 select the target. 00 is the memory array, 10 is the control/status register and 11 is the potentiometer registers. `target` reports that code. Code 01 is rejected.
- R5: Bit 0 gives the direction: 1 is read and 0 is write. `is_read` reports it.
- R6: A write (bit 0 = 0) to target 00 or 11 is rejected while `wr_en_latch` is 0 and accepted while it is 1. A write to target 10 is accepted whatever `wr_en_latch` is. Reads are never gated.
- R7: `txn_active` is 1 from the start of the acknowledge until the next STOP or START. After a rejected byte, further bytes without a new START get no acknowledge.
- R8: A STOP or a repeated START at any point, including in the middle of a byte, clears `txn_active` and the bit count. A START restarts address reception.
- R9: After reset, `sda_oe` and `txn_active` are 0.
- R10: `sda_oe` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| addr_strap | input | 1 | Physical address strap level |
| wr_en_latch | input | 1 | Write-enable latch state |
| sda_oe | output | 1 | 1 = pull SDA low (acknowledge) |
| txn_active | output | 1 | Addressed transaction in progress |
| target | output | 2 | Selected internal target code |
| is_read | output | 1 | 1 = read transaction |

## Verification
The bench goes after each of the following corner cases:
- Each rejection cause on its own: a wrong type code, a strap mismatch, selector 01, and a gated write with the latch clear. A design that ignored any one of these checks would acknowledge a byte that is not its own.
- A valid-looking byte sent after a rejection without a new START. A design that does not stay in the ignore state would acknowledge it.
- A repeated START after an accepted byte, a START in the middle of a byte, and a STOP in the middle of a byte. A design that kept a stale bit count would misalign the next address or keep `txn_active` high.
- The moments around the acknowledge window. A design that drove SDA while SCL was still high after the eighth bit, or held it past the ninth clock, would be seen doing so.

// File: rtl/twsl_pkg.sv
package twsl_pkg;

    localparam int ADDR_BITS = 8;
    localparam logic [3:0] DEV_TYPE_CODE = 4'b1010;

    typedef enum logic [1:0] {
        TGT_MEM  = 2'b00,
        TGT_RSVD = 2'b01,
        TGT_CSR  = 2'b10,
        TGT_POT  = 2'b11
    } tgt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_ACK_WAIT,
        ST_ACK_DRIVE,
        ST_ACTIVE,
        ST_IGNORE
    } fsm_e;

endpackage

// File: rtl/twsl_sync.sv
module twsl_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '1;
            end else if (s == 0) begin
                stage_q[s] <= d_in;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/twsl_cond_det.sv
module twsl_cond_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_evt,
    output logic stop_evt,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        start_evt = scl_s & scl_q & sda_q & ~sda_s;
        stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
    end
endmodule

// File: rtl/twsl_addr_fsm.sv
module twsl_addr_fsm
    import twsl_pkg::*;
#(
    parameter int BITS = ADDR_BITS
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_lvl,
    input  logic       sda_lvl,
    input  logic       start_evt,
    input  logic       stop_evt,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       addr_strap,
    input  logic       wr_en_latch,
    output logic       sda_oe,
    output logic       txn_active,
    output logic [1:0] target,
    output logic       is_read
);
    localparam int CNT_W = $clog2(BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BITS - 1);

    fsm_e             state_q, state_d;
    logic [BITS-1:0]  shift_q, shift_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    tgt_e             tgt_q, tgt_d;
    logic             rd_q, rd_d;
    logic [BITS-1:0]  full_byte;
    logic             accept;

    assign full_byte = {shift_q[BITS-2:0], sda_lvl};

    always_comb begin
        accept = (full_byte[7:4] == DEV_TYPE_CODE)
               && (full_byte[3] == addr_strap)
               && (tgt_e'(full_byte[2:1]) != TGT_RSVD)
               && (full_byte[0] || tgt_e'(full_byte[2:1]) == TGT_CSR || wr_en_latch);
    end

    always_comb begin
        state_d = state_q;
        shift_d = shift_q;
        cnt_d   = cnt_q;
        tgt_d   = tgt_q;
        rd_d    = rd_q;
        if (start_evt) begin
            state_d = ST_SHIFT;
            cnt_d   = '0;
        end else if (stop_evt) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_ACTIVE, ST_IGNORE: ;
                ST_SHIFT: begin
                    if (scl_rise) begin
                        shift_d = full_byte;
                        cnt_d   = cnt_q + 1'b1;
                        if (cnt_q == LAST_BIT) begin
                            cnt_d = '0;
                            if (accept) begin
                                state_d = ST_ACK_WAIT;
                                tgt_d   = tgt_e'(full_byte[2:1]);
                                rd_d    = full_byte[0];
                            end else begin
                                state_d = ST_IGNORE;
                            end
                        end
                    end
                end
                ST_ACK_WAIT:  if (scl_fall) state_d = ST_ACK_DRIVE;
                ST_ACK_DRIVE: if (scl_fall) state_d = ST_ACTIVE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            shift_q <= '0;
            cnt_q   <= '0;
            tgt_q   <= TGT_MEM;
            rd_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            shift_q <= shift_d;
            cnt_q   <= cnt_d;
            tgt_q   <= tgt_d;
            rd_q    <= rd_d;
        end
    end

    always_comb begin
        sda_oe     = 1'b0;
        txn_active = 1'b0;
        unique case (state_q)
            ST_ACK_DRIVE: begin
                sda_oe     = 1'b1;
                txn_active = 1'b1;
            end
            ST_ACTIVE: txn_active = 1'b1;
            ST_IDLE, ST_SHIFT, ST_ACK_WAIT, ST_IGNORE: ;
            default: ;
        endcase
        target  = tgt_q;
        is_read = rd_q;
    end

    assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_lvl);

    assert_ack_after_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !txn_active);

    assert_stop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (!txn_active && !sda_oe));

    assert_no_rsvd_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        txn_active |-> (target != TGT_RSVD));
endmodule

// File: rtl/twsl_addr_front.sv
module twsl_addr_front
    import twsl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       addr_strap,
    input  logic       wr_en_latch,
    output logic       sda_oe,
    output logic       txn_active,
    output logic [1:0] target,
    output logic       is_read
);
    logic [1:0] bus_s;
    logic start_evt, stop_evt, scl_rise, scl_fall;

    twsl_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({scl_in, sda_in}),
        .d_out (bus_s)
    );

    twsl_cond_det u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (bus_s[1]),
        .sda_s     (bus_s[0]),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall)
    );

    twsl_addr_fsm #(.BITS(ADDR_BITS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_lvl     (bus_s[1]),
        .sda_lvl     (bus_s[0]),
        .start_evt   (start_evt),
        .stop_evt    (stop_evt),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .addr_strap  (addr_strap),
        .wr_en_latch (wr_en_latch),
        .sda_oe      (sda_oe),
        .txn_active  (txn_active),
        .target      (target),
        .is_read     (is_read)
    );
endmodule

// File: tb/sim_twsl_addr_front.sv
module sim_twsl_addr_front;
    localparam int QT = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic strap = 1'b0;
    logic wen = 1'b0;
    logic sda_oe, txn_active, is_read;
    logic [1:0] target;
    wire sda_line = sda_m & ~sda_oe;

    int n_checks = 0;
    int n_fail = 0;
    logic pre_ack;

    typedef struct {
        logic ack;
        logic act;
        logic chk;
        logic [1:0] tgt;
        logic rd;
        string req;
    } exp_t;
    exp_t sb_q[$];
    event mon_ev;

    always #2.5 clk = ~clk;

    twsl_addr_front u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .addr_strap(strap), .wr_en_latch(wen),
        .sda_oe(sda_oe), .txn_active(txn_active), .target(target), .is_read(is_read)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n = 1);
        repeat (n * QT) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq();
        scl_m = 1'b1; wq();
        pre_ack = sda_oe;
        wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, input logic ack, input logic act,
                             input logic chk_t, input logic [1:0] tgt, input logic rd,
                             input string req);
        exp_t e;
        e.ack = ack; e.act = act; e.chk = chk_t; e.tgt = tgt; e.rd = rd; e.req = req;
        sb_q.push_back(e);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        -> mon_ev;
        wq();
        scl_m = 1'b0; wq();
    endtask

    initial begin
        forever begin
            exp_t e;
            @(mon_ev);
            e = sb_q.pop_front();
            chk({e.req, " ack"}, {7'd0, sda_oe}, {7'd0, e.ack});
            chk({e.req, " active"}, {7'd0, txn_active}, {7'd0, e.act});
            if (e.chk) begin
                chk({e.req, " target"}, {6'd0, target}, {6'd0, e.tgt});
                chk({e.req, " dir"}, {7'd0, is_read}, {7'd0, e.rd});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk("R9 sda_oe at reset", {7'd0, sda_oe}, 8'd0);
        chk("R9 active at reset", {7'd0, txn_active}, 8'd0);
        rst_n = 1'b1;
        wq(2);

        // write to control/status with latch clear
        bus_start();
        send_byte(8'hA4, 1, 1, 1, 2'b10, 0, "R6 csr write ungated");
        chk("R10 no drive in 8th high", {7'd0, pre_ack}, 8'd0);
        wq();
        chk("R1 ack released", {7'd0, sda_oe}, 8'd0);
        chk("R7 active after ack", {7'd0, txn_active}, 8'd1);
        bus_stop(); wq();
        chk("R7 stop clears active", {7'd0, txn_active}, 8'd0);

        bus_start();
        send_byte(8'hA1, 1, 1, 1, 2'b00, 1, "R5 mem read");
        bus_stop();
        bus_start();
        send_byte(8'hA7, 1, 1, 1, 2'b11, 1, "R4 pot read");
        bus_stop();

        bus_start();
        send_byte(8'hA0, 0, 0, 0, 2'b00, 0, "R6 mem write gated");
        bus_stop();
        bus_start();
        send_byte(8'hA6, 0, 0, 0, 2'b00, 0, "R6 pot write gated");
        bus_stop();
        wen = 1'b1;
        bus_start();
        send_byte(8'hA0, 1, 1, 1, 2'b00, 0, "R6 mem write enabled");
        bus_stop();
        bus_start();
        send_byte(8'hA6, 1, 1, 1, 2'b11, 0, "R6 pot write enabled");
        bus_stop();

        bus_start();
        send_byte(8'hB4, 0, 0, 0, 2'b00, 0, "R2 wrong type code");
        send_byte(8'hA4, 0, 0, 0, 2'b00, 0, "R7 ignored after reject");
        bus_stop();

        strap = 1'b1;
        bus_start();
        send_byte(8'hA4, 0, 0, 0, 2'b00, 0, "R3 strap mismatch");
        bus_stop();
        bus_start();
        send_byte(8'hAC, 1, 1, 1, 2'b10, 0, "R3 strap match");
        bus_stop();
        strap = 1'b0;

        bus_start();
        send_byte(8'hA3, 0, 0, 0, 2'b00, 0, "R4 selector 01 rejected");
        bus_stop();

        bus_start();
        send_byte(8'hA5, 1, 1, 1, 2'b10, 1, "R8 first before restart");
        bus_start();
        chk("R8 restart clears active", {7'd0, txn_active}, 8'd0);
        send_byte(8'hA1, 1, 1, 1, 2'b00, 1, "R8 after restart");
        bus_stop();

        bus_start();
        send_bit(1); send_bit(0); send_bit(1);
        bus_start();
        send_byte(8'hA7, 1, 1, 1, 2'b11, 1, "R8 start mid-byte");
        bus_stop();

        bus_start();
        send_bit(1); send_bit(0); send_bit(1);
        bus_stop(); wq();
        chk("R8 stop mid-byte", {7'd0, txn_active}, 8'd0);
        sda_m = 1'b1; wq();
        scl_m = 1'b0; wq();
        send_byte(8'hA4, 0, 0, 0, 2'b00, 0, "R8 idle after stop");
        scl_m = 1'b1; wq();
        bus_stop();

        bus_start();
        send_byte(8'hA4, 1, 1, 1, 2'b10, 0, "R1 ack on accepted");
        wq();
        chk("R1 release after ninth", {7'd0, sda_oe}, 8'd0);
        bus_stop();

        wq(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule